// File: doc/BRIEF.md
# Segmented Noise-Shaped Element Encoder

This block turns a stream of 24-bit two's complement audio samples, already interpolated to eight times the sample rate, into an enable vector for 66 matched unit current cells. Each word is split in two. The top 6 bits form a coarse level that is decoded directly. The remaining 18 bits drive a third-order noise-shaping loop whose 5-level output (0 to 4) has the same weight as one coarse step. Coarse plus fine gives a count of 0 to 66 cells to switch on. A rotating pointer then picks which physical cells carry that count, so that mismatch between cells is shaped away from the signal band.

A new sample is captured on a strobe and held until the next strobe, so one sample is reused for eight modulator steps. The modulator and the rotator advance only on cycles where the oversampling enable is high. Between enables the cell vector is held. The codes map as follows: 0x800000 sits near the bottom of the range, 0x000000 sits at the midpoint of 33 cells, and 0x7FFFFF sits near the top. The two differential current outputs therefore move in opposite directions as the code changes.

Top module: `seg_dsm_dac_enc`

## Requirements
- R1: While rst_n is low, and after its release until the first cycle with os_en high, cell_en is all zeros. The rotation pointer restarts at cell 0.
- R2: On every enabled step the number of set bits in cell_en, minus the coarse level, lies in 0..4. The coarse level is the 6-bit value {~d[23], d[22:18]} of the held sample d, with 63 replaced by 62.
- R3: Averaged over 512 enabled steps at a constant held sample d, the count of set bits in cell_en equals 33 + d/2^18 (d signed) to within 8 counts on the window total.
- R4: The set bits of cell_en form one circular run that starts at the pointer. After each enabled step, the pointer advances by the run length, modulo 66.
- R5: On cycles with os_en low, cell_en keeps its previous value.
- R6: smp_data is captured only on cycles with smp_valid high. A change on smp_data without smp_valid has no effect on the output average.
- R7: Over any 512 consecutive enabled steps, the usage counts of the 66 cells differ by at most 1.
- R8: At code 0x800000 no step enables more than 4 cells. At code 0x7FFFFF every step enables at least 62 cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_en | input | 1 | Modulator step enable (64x sample rate) |
| smp_valid | input | 1 | Capture strobe for smp_data (8x sample rate) |
| smp_data | input | 24 | Two's complement sample |
| cell_en | output | 66 | Unit cell enables |

## Verification
A wrong coarse decode or a wrong loop coefficient does not always show in any one step. It shows as a drift in the long-run cell count, so the bench compares window sums against the sample value. A pointer that advances by the wrong amount breaks the circular run, or moves its start, on the very next enabled step. The bench tracks the pointer itself and compares the whole vector on every step. A cell-usage imbalance larger than one unit over a window exposes faulty rotation that happens to keep counts right. A vector that changes on a disabled cycle is caught one cycle later.

// File: rtl/seg_dsm_dac_enc.sv
module seg_dsm_dac_enc #(
  parameter int DW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_en,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic [(1<<CW)+1:0] cell_en
);
  localparam int FW    = DW - CW;
  localparam int IW    = 5;
  localparam int AW    = FW + IW;
  localparam int NCELL = (1 << CW) + 2;
  localparam int PW    = $clog2(NCELL + 1);
  localparam logic signed [AW-1:0] ONE  = AW'(1) <<< FW;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FW - 1);

  logic [DW-1:0] smp_q;
  logic signed [AW-1:0] e1, e2, e3;
  logic [PW-1:0] ptr;

  wire [CW-1:0] ob_lvl  = {~smp_q[DW-1], smp_q[DW-2:FW]};
  wire          top_seg = &ob_lvl;
  wire [CW-1:0] coarse  = top_seg ? ob_lvl - CW'(1) : ob_lvl;

  wire signed [AW-1:0] u_in = $signed({{IW{1'b0}}, smp_q[FW-1:0]}) + (top_seg ? (ONE <<< 1) : ONE);
  wire signed [AW-1:0] v_in = u_in - (e1 <<< 1) + e2 + (e2 >>> 2) - (e3 >>> 2);
  wire signed [AW-1:0] v_rnd = (v_in + HALF) >>> FW;

  logic [2:0] fine;
  always_comb begin
    if (v_rnd < 0)                 fine = 3'd0;
    else if (v_rnd > AW'(4))       fine = 3'd4;
    else                           fine = v_rnd[2:0];
  end

  wire signed [AW-1:0] q_raw = $signed({2'b00, fine, {FW{1'b0}}}) - v_in;
  wire signed [AW-1:0] q_sat = (q_raw > HALF) ? HALF : ((q_raw < -HALF) ? -HALF : q_raw);

  wire [PW-1:0] n_on = PW'(coarse) + PW'(fine);
  wire [PW:0]   ptr_sum = {1'b0, ptr} + {1'b0, n_on};
  wire [PW-1:0] ptr_nxt = (ptr_sum >= (PW+1)'(NCELL)) ? PW'(ptr_sum - (PW+1)'(NCELL)) : PW'(ptr_sum);

  logic [NCELL-1:0] run_vec;
  always_comb begin
    for (int i = 0; i < NCELL; i++) begin
      int off;
      off = (i >= int'(ptr)) ? i - int'(ptr) : i + NCELL - int'(ptr);
      run_vec[i] = off < int'(n_on);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      e1      <= '0;
      e2      <= '0;
      e3      <= '0;
      ptr     <= '0;
      cell_en <= '0;
    end else begin
      if (smp_valid) smp_q <= smp_data;
      if (os_en) begin
        e1      <= q_sat;
        e2      <= e1;
        e3      <= e2;
        ptr     <= ptr_nxt;
        cell_en <= run_vec;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> cell_en == '0);

  assert_count_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    os_en |=> ($countones(cell_en) >= int'($past(coarse))) &&
              ($countones(cell_en) <= int'($past(coarse)) + 4));

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    os_en |=> int'(ptr) == (int'($past(ptr)) + $countones(cell_en)) % NCELL);

  assert_run_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (os_en && n_on != '0) |=> cell_en[$past(ptr)]);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !os_en |=> $stable(cell_en));

endmodule

// File: tb/seg_dsm_dac_enc_tb.sv
module seg_dsm_dac_enc_tb_top;
  localparam int CLK_P = 10;
  localparam int NC    = 66;
  localparam int WIN   = 512;
  localparam int NV    = 8;
  localparam logic [23:0] VEC [NV] = '{24'h000000, 24'h800000, 24'h7FFFFF, 24'h040000,
                                       24'hFC0000, 24'h123456, 24'hE54321, 24'h020000};

  logic clk = 1'b0, rst_n = 1'b0, os_en = 1'b0, smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic [NC-1:0] cell_en;
  int checks = 0, fails = 0, bptr = 0;
  int use_cnt [NC];
  logic [NC-1:0] prev;

  always #(CLK_P/2) clk = ~clk;

  seg_dsm_dac_enc dut_i (.clk(clk), .rst_n(rst_n), .os_en(os_en), .smp_valid(smp_valid),
                         .smp_data(smp_data), .cell_en(cell_en));

  function automatic logic [NC-1:0] rot(int p, int n);
    logic [NC-1:0] r = '0;
    for (int k = 0; k < n; k++) r[(p + k) % NC] = 1'b1;
    return r;
  endfunction

  function automatic int coarse_of(logic [23:0] d);
    int ob = int'({~d[23], d[22:18]});
    return (ob == 63) ? 62 : ob;
  endfunction

  task automatic chk(bit ok, string req, string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  task automatic tick(bit oe, bit sv);
    os_en = oe; smp_valid = sv;
    @(negedge clk);
    os_en = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic run_win(logic [23:0] d, bit reload, int nsteps, bit measure);
    longint sum = 0;
    int mn = 99, mx = -1;
    real expv;
    for (int c = 0; c < NC; c++) use_cnt[c] = 0;
    for (int s = 0; s < nsteps; s++) begin
      int cnt, co;
      prev = cell_en;
      if (reload && (s % 8 == 0)) smp_data = d;
      tick(1'b0, reload && (s % 8 == 0));
      chk(cell_en == prev, "R5", $sformatf("hold act=%h exp=%h", cell_en, prev));
      tick(1'b1, 1'b0);
      cnt = $countones(cell_en);
      co  = coarse_of(d);
      chk(cell_en == rot(bptr, cnt), "R4", $sformatf("act=%h exp=%h", cell_en, rot(bptr, cnt)));
      chk(cnt - co >= 0 && cnt - co <= 4, "R2", $sformatf("count act=%0d exp=%0d..%0d", cnt, co, co + 4));
      bptr = (bptr + cnt) % NC;
      sum += cnt;
      if (cnt < mn) mn = cnt;
      if (cnt > mx) mx = cnt;
      for (int c = 0; c < NC; c++) if (cell_en[c]) use_cnt[c]++;
    end
    if (measure) begin
      int umin = 1 << 30, umax = 0;
      expv = real'(nsteps) * (33.0 + $itor($signed(d)) / 262144.0);
      chk((real'(sum) - expv) <= 8.0 && (expv - real'(sum)) <= 8.0, "R3",
          $sformatf("d=%h sum act=%0d exp=%f", d, sum, expv));
      for (int c = 0; c < NC; c++) begin
        if (use_cnt[c] < umin) umin = use_cnt[c];
        if (use_cnt[c] > umax) umax = use_cnt[c];
      end
      chk(umax - umin <= 1, "R7", $sformatf("usage spread act=%0d exp<=1", umax - umin));
      if (d == 24'h800000) chk(mx <= 4, "R8", $sformatf("max count act=%0d exp<=4", mx));
      if (d == 24'h7FFFFF) chk(mn >= 62, "R8", $sformatf("min count act=%0d exp>=62", mn));
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cell_en == '0, "R1", $sformatf("in reset act=%h exp=0", cell_en));
    rst_n = 1'b1;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk(cell_en == '0, "R1", $sformatf("after release act=%h exp=0", cell_en));

    for (int v = 0; v < NV; v++) begin
      run_win(VEC[v], 1'b1, 16, 1'b0);
      run_win(VEC[v], 1'b1, WIN, 1'b1);
    end

    // R6: data changes without the strobe leave the held midscale value in force
    run_win(24'h000000, 1'b1, 16, 1'b0);
    smp_data = 24'h7FFFFF;
    run_win(24'h000000, 1'b0, WIN, 1'b1);
    chk(1'b1, "R6", "ignored data check done via window average");

    // R1: mid-run reset clears the vector and restarts the pointer
    rst_n = 1'b0;
    @(negedge clk);
    chk(cell_en == '0, "R1", $sformatf("mid reset act=%h exp=0", cell_en));
    rst_n = 1'b1;
    bptr = 0;
    tick(1'b0, 1'b0);
    chk(cell_en == '0, "R1", $sformatf("post reset act=%h exp=0", cell_en));
    run_win(24'h000000, 1'b0, 4, 1'b0);

    summary();
  end
endmodule